// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver with Sticky Status

This block turns an asynchronous serial line into 8-bit characters. An enable pulse that the host logic supplies at `OSR` times the bit rate (16 by default) paces the receiver. A frame consists of a low start bit, eight data bits sent least significant bit first, an optional parity bit, and one stop bit. Each finished character goes into a holding register, which the block presents on `rx_data`.

Three status flags go with the holding register. `rx_ready` means an unread character is waiting, and a read strobe clears it. `rx_overrun` and `rx_par_err` are sticky. Only a control write with the status-clear bit set clears them. The parity scheme comes from a 3-bit mode input, which the block captures when each start bit begins.

Top module: `uart_rx_status`

## Requirements
- R1: When the stop-bit sample of a frame is taken, the eight data bits appear on `rx_data` (first received bit in bit 0) and `rx_ready` is 1 from the next clock. `rx_data` changes at no other time.
- R2: A start is detected at a tick where the synchronised line is 0 and it was 1 at the previous tick. The ticks of the start bit are numbered from 1. Three samples are taken at ticks OSR/2-1, OSR/2 and OSR/2+1. If two or more of them are high, the start is dropped, the receiver goes back to idle, and no character is delivered.
- R3: Each later bit is sampled once, exactly OSR ticks after the sample of the bit before it, at tick OSR/2 of that bit. Line values elsewhere in the bit have no effect.
- R4: A pulse on `rd_strobe` clears `rx_ready` unless a character completes in the same cycle.
- R5: If a character completes while `rx_ready` is 1 and no read happens in that cycle, `rx_overrun` becomes 1, `rx_data` takes the newest character, and `rx_ready` stays 1.
- R6: If a read and a character completion fall in the same cycle, `rx_ready` ends at 1 and no overrun is recorded.
- R7: `par_mode` encodings: 0 is even, 1 is odd, 2 is a parity bit that must be 0, 3 is a parity bit that must be 1, and 4 to 7 mean no parity. For modes 0 to 3, a wrong parity bit sets `rx_par_err` in the same cycle that `rx_ready` is set.
- R8: With no parity, the frame has no parity bit (stop follows data bit 7) and `rx_par_err` is never set.
- R9: `rx_overrun` and `rx_par_err` hold through later good characters and through reads. A `ctrl_wr` pulse with `ctrl_wdata[3]`=1 clears both. A control write with bit 3 at 0 leaves them unchanged.
- R10: After reset, `rx_data` is 0 and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle enable pulse at OSR times the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| rd_strobe | input | 1 | Read of the holding register |
| ctrl_wr | input | 1 | Control-register write strobe |
| ctrl_wdata | input | 8 | Control write data; bit 3 clears the sticky flags |
| par_mode | input | 3 | Parity scheme, captured at start detection |
| rx_data | output | 8 | Receive holding register |
| rx_ready | output | 1 | An unread character is held |
| rx_overrun | output | 1 | Sticky: a character arrived while one was still unread |
| rx_par_err | output | 1 | Sticky: a character had a wrong parity bit |

## Verification
The bench sweeps all 256 data values across all five parity schemes. A wrong bit order or a misplaced sample point would show up as corrupted characters, and a receiver that expected a parity bit in no-parity mode would slip into the next frame. It drives low pulses too short to win the start vote, which a design without the vote would take as phantom characters. It also places a single high tick at the start-bit centre and skews the bit edges around the sample point; a receiver that sampled at the wrong tick would decode these wrongly. The checks on the flags cover these cases: a read that falls in the exact cycle a character completes, where a naive design reports a false overrun or loses the ready flag; error flags that must survive good characters and control writes without the clear bit; and unread characters piling up, which must overwrite the holding register.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int CHAR_BITS   = 8;
    localparam int CTRL_W      = 8;
    localparam int STS_CLR_BIT = 3;
    localparam int MODE_W      = 3;

    typedef enum logic [MODE_W-1:0] {
        PM_EVEN  = 3'd0,
        PM_ODD   = 3'd1,
        PM_SPACE = 3'd2,
        PM_MARK  = 3'd3,
        PM_NONE  = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_BITS-1:0] data;
        logic                 par_bad;
    } rx_char_t;

    function automatic logic parity_on(input logic [MODE_W-1:0] mode);
        return mode < MODE_W'(PM_NONE);
    endfunction

    function automatic logic parity_expected(input logic [MODE_W-1:0] mode,
                                             input logic [CHAR_BITS-1:0] data);
        logic res;
        case (mode)
            MODE_W'(PM_EVEN):  res = ^data;
            MODE_W'(PM_ODD):   res = ~^data;
            MODE_W'(PM_SPACE): res = 1'b0;
            default:           res = 1'b1;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_out
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sr <= '1;
                else     sr <= line_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= '1;
                else     sr <= {sr[STAGES-2:0], line_in};
            end
        end
    endgenerate

    assign line_out = sr[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              line,
    input  logic [MODE_W-1:0] mode_in,
    output logic              done,
    output rx_char_t          chr,
    output logic              par_on
);
    localparam int CNT_W = $clog2(OSR);
    localparam int BN_W  = $clog2(CHAR_BITS);
    localparam logic [CNT_W-1:0] MID      = CNT_W'(OSR / 2);
    localparam logic [CNT_W-1:0] VOTE_LO  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] VOTE_HI  = CNT_W'(OSR / 2 + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
    localparam logic [BN_W-1:0]  BIT_LAST = BN_W'(CHAR_BITS - 1);

    rx_state_e            state;
    logic [CNT_W-1:0]     cnt;
    logic [CNT_W-1:0]     cnt_nx;
    logic [BN_W-1:0]      bitn;
    logic [CHAR_BITS-1:0] shreg;
    logic                 par_q;
    logic [MODE_W-1:0]    mode_q;
    logic                 prev_line;
    logic [1:0]           vote;
    logic [1:0]           vote_nx;
    logic                 in_window;

    assign cnt_nx    = (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
    assign in_window = (cnt_nx >= VOTE_LO) && (cnt_nx <= VOTE_HI);
    assign vote_nx   = vote + {1'b0, ~line};

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            bitn      <= '0;
            shreg     <= '0;
            par_q     <= 1'b0;
            mode_q    <= MODE_W'(PM_NONE);
            prev_line <= 1'b1;
            vote      <= '0;
        end else if (tick) begin
            prev_line <= line;
            case (state)
                ST_IDLE: begin
                    if (prev_line && !line) begin
                        state  <= ST_START;
                        cnt    <= CNT_W'(1);
                        vote   <= '0;
                        mode_q <= mode_in;
                    end
                end
                ST_START: begin
                    cnt <= cnt_nx;
                    if (in_window) vote <= vote_nx;
                    if (cnt_nx == VOTE_HI) begin
                        if (vote_nx >= 2'd2) begin
                            state <= ST_DATA;
                            bitn  <= '0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_DATA: begin
                    cnt <= cnt_nx;
                    if (cnt_nx == MID) begin
                        shreg <= {line, shreg[CHAR_BITS-1:1]};
                        bitn  <= bitn + 1'b1;
                        if (bitn == BIT_LAST)
                            state <= parity_on(mode_q) ? ST_PAR : ST_STOP;
                    end
                end
                ST_PAR: begin
                    cnt <= cnt_nx;
                    if (cnt_nx == MID) begin
                        par_q <= line;
                        state <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    cnt <= cnt_nx;
                    if (cnt_nx == MID) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign par_on      = parity_on(mode_q);
    assign done        = tick && (state == ST_STOP) && (cnt_nx == MID);
    assign chr.data    = shreg;
    assign chr.par_bad = par_on && (par_q != parity_expected(mode_q, shreg));
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
    import uart_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 done,
    input  rx_char_t             chr,
    input  logic                 rd,
    input  logic                 clr,
    output logic [CHAR_BITS-1:0] hold,
    output logic                 ready,
    output logic                 ovr,
    output logic                 perr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold  <= '0;
            ready <= 1'b0;
            ovr   <= 1'b0;
            perr  <= 1'b0;
        end else begin
            if (done)      hold <= chr.data;

            if (done)      ready <= 1'b1;
            else if (rd)   ready <= 1'b0;

            if (done && ready && !rd) ovr <= 1'b1;
            else if (clr)             ovr <= 1'b0;

            if (done && chr.par_bad)  perr <= 1'b1;
            else if (clr)             perr <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 os_tick,
    input  logic                 rxd,
    input  logic                 rd_strobe,
    input  logic                 ctrl_wr,
    input  logic [CTRL_W-1:0]    ctrl_wdata,
    input  logic [MODE_W-1:0]    par_mode,
    output logic [CHAR_BITS-1:0] rx_data,
    output logic                 rx_ready,
    output logic                 rx_overrun,
    output logic                 rx_par_err
);
    logic     line_s;
    logic     char_done;
    rx_char_t char_q;
    logic     frame_par_on;
    logic     status_clr;
    logic     ctrl_unused;

    assign status_clr  = ctrl_wr && ctrl_wdata[STS_CLR_BIT];
    assign ctrl_unused = &{1'b0, ctrl_wdata};

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .line_in  (rxd),
        .line_out (line_s)
    );

    rx_frame_fsm #(.OSR(OSR)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .tick    (os_tick),
        .line    (line_s),
        .mode_in (par_mode),
        .done    (char_done),
        .chr     (char_q),
        .par_on  (frame_par_on)
    );

    rx_status_regs u_sts (
        .clk   (clk),
        .rst   (rst),
        .done  (char_done),
        .chr   (char_q),
        .rd    (rd_strobe),
        .clr   (status_clr),
        .hold  (rx_data),
        .ready (rx_ready),
        .ovr   (rx_overrun),
        .perr  (rx_par_err)
    );
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_strobe,
    input logic       status_clr,
    input logic       char_done,
    input logic       char_par_bad,
    input logic [7:0] rx_data,
    input logic       rx_ready,
    input logic       rx_overrun,
    input logic       rx_par_err
);
    AST_DONE_SETS_READY: assert property (@(posedge clk) disable iff (rst)
        char_done |=> rx_ready); // R1

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !char_done |=> $stable(rx_data)); // R1

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rd_strobe && !char_done |=> !rx_ready); // R4

    AST_OVR_ON_UNREAD: assert property (@(posedge clk) disable iff (rst)
        char_done && rx_ready && !rd_strobe |=> rx_overrun && rx_ready); // R5

    AST_READ_RACE: assert property (@(posedge clk) disable iff (rst)
        char_done && rd_strobe && !rx_overrun |=> rx_ready && !rx_overrun); // R6

    AST_PERR_WITH_READY: assert property (@(posedge clk) disable iff (rst)
        char_done && char_par_bad |=> rx_par_err && rx_ready); // R7

    AST_PERR_NO_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !rx_par_err && !(char_done && char_par_bad) |=> !rx_par_err); // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        rx_overrun && !status_clr |=> rx_overrun); // R9

    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        rx_par_err && !status_clr |=> rx_par_err); // R9

    AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (rst)
        status_clr && !char_done |=> !rx_overrun && !rx_par_err); // R9
endmodule

bind uart_rx_status uart_rx_status_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_strobe    (rd_strobe),
    .status_clr   (status_clr),
    .char_done    (char_done),
    .char_par_bad (char_q.par_bad),
    .rx_data      (rx_data),
    .rx_ready     (rx_ready),
    .rx_overrun   (rx_overrun),
    .rx_par_err   (rx_par_err)
);

// File: tb/uart_rx_status_tb.sv
module uart_rx_status_tb;
    localparam int OSR  = 8;
    localparam int MID  = OSR / 2;
    localparam int WDOG = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rd_strobe = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [2:0] par_mode = 3'd4;
    logic [7:0] rx_data;
    logic       rx_ready, rx_overrun, rx_par_err;

    int nvec = 0;
    int nerr = 0;
    bit finished = 0;

    logic [7:0] e_data = '0;
    logic       e_rdy = 0, e_ovr = 0, e_perr = 0;

    always #5 clk = ~clk;

    uart_rx_status #(.OSR(OSR), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
        .rd_strobe(rd_strobe), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .par_mode(par_mode), .rx_data(rx_data), .rx_ready(rx_ready),
        .rx_overrun(rx_overrun), .rx_par_err(rx_par_err)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk({req, " data"}, rx_data, e_data);
        chk({req, " ready"}, {7'd0, rx_ready}, {7'd0, e_rdy});
        chk({req, " overrun"}, {7'd0, rx_overrun}, {7'd0, e_ovr});
        chk({req, " parity_err"}, {7'd0, rx_par_err}, {7'd0, e_perr});
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    endtask

    task automatic do_tick(input logic rd_now);
        repeat (2) @(negedge clk);
        os_tick = 1'b1;
        rd_strobe = rd_now;
        @(negedge clk);
        os_tick = 1'b0;
        rd_strobe = 1'b0;
    endtask

    task automatic hold_bit(input logic v, input int n);
        rxd = v;
        for (int i = 0; i < n; i++) do_tick(1'b0);
    endtask

    function automatic logic exp_par(input logic [2:0] m, input logic [7:0] d);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += d[i];
        case (m)
            3'd0: return logic'(ones % 2);
            3'd1: return logic'(1 - ones % 2);
            3'd2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    // blip: single high tick at start centre; skew: bit edges disturbed
    task automatic send_frame(input logic [7:0] d, input logic [2:0] m, input logic bad,
                              input logic race, input logic blip, input logic skew);
        par_mode = m;
        if (blip) begin
            hold_bit(1'b0, MID - 1);
            hold_bit(1'b1, 1);
            hold_bit(1'b0, OSR - MID);
        end else begin
            hold_bit(1'b0, OSR);
        end
        for (int b = 0; b < 8; b++) begin
            if (skew) begin
                hold_bit(~d[b], 2);
                hold_bit(d[b], OSR - 4);
                hold_bit(~d[b], 2);
            end else begin
                hold_bit(d[b], OSR);
            end
        end
        if (m < 3'd4) hold_bit(exp_par(m, d) ^ bad, OSR);
        rxd = 1'b1;
        for (int i = 1; i <= OSR; i++) do_tick(race && (i == MID));
        hold_bit(1'b1, 3);
        // expected status after the frame
        if (race) e_rdy = 1;
        else begin
            if (e_rdy) e_ovr = 1;
            e_rdy = 1;
        end
        if (m < 3'd4 && bad) e_perr = 1;
        e_data = d;
        // race read consumed nothing extra; flags follow R6
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        e_rdy = 0;
    endtask

    task automatic do_ctrl(input logic [7:0] v);
        @(negedge clk);
        ctrl_wr = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
        ctrl_wdata = '0;
        if (v[3]) begin
            e_ovr = 0;
            e_perr = 0;
        end
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired: actual=running expected=done");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_all("R10 reset");

        // R1 R3 R8: every data value, all parity schemes, good parity
        for (int v = 0; v < 256; v++) begin
            send_frame(v[7:0], 3'(v % 5), 1'b0, 1'b0, 1'b0, 1'b0);
            chk_all((v % 5 == 4) ? "R8 no-parity frame" : "R1 frame");
            do_read();
            chk("R4 read clears ready", {7'd0, rx_ready}, 8'd0);
        end

        // no-parity codes above 4
        send_frame(8'hC3, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0);
        chk_all("R8 mode 7");
        do_read();

        // R7 R9: wrong parity per scheme
        for (int m = 0; m < 4; m++) begin
            send_frame(8'h5A + 8'(m), 3'(m), 1'b1, 1'b0, 1'b0, 1'b0);
            chk_all("R7 parity error");
            do_read();
            send_frame(8'h11 * 8'(m + 1), 3'(m), 1'b0, 1'b0, 1'b0, 1'b0);
            chk_all("R9 perr sticky over good char");
            do_read();
            do_ctrl(8'hF7);
            chk_all("R9 ctrl write without clear bit");
            do_ctrl(8'h08);
            chk_all("R9 clear command");
        end

        // R5 overrun
        send_frame(8'hA1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk_all("R5 first unread");
        send_frame(8'hB2, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk_all("R5 overrun");
        send_frame(8'hC4, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0);
        chk_all("R5 overrun again");
        do_read();
        chk_all("R9 ovr survives read");
        do_ctrl(8'h08);
        chk_all("R9 ovr cleared");

        // R6 read in completion cycle
        send_frame(8'h3C, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(8'h96, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk_all("R6 read race");
        do_read();
        chk_all("R6 after read");

        // R2 glitch too short for the vote
        for (int g = 1; g < MID; g++) begin
            hold_bit(1'b0, g);
            hold_bit(1'b1, 3 * OSR);
            chk_all("R2 glitch dropped");
        end
        // R2 single high tick at centre loses the vote
        send_frame(8'h69, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        chk_all("R2 blip start accepted");
        do_read();

        // R3 disturbed bit edges
        for (int v = 0; v < 8; v++) begin
            send_frame(8'h1F ^ 8'(v * 37), 3'(v % 5), 1'b0, 1'b0, 1'b0, 1'b1);
            chk_all("R3 skewed edges");
            do_read();
        end

        summary();
    end
endmodule